// File: doc/BRIEF.md
# DMA Acknowledge Watchdog and Request Router

This block sits between an ISA-style host bus and one removable card socket and manages that socket's DMA traffic. A two-bit mode field turns DMA on and picks which of three active-low card pins carries the card's DMA request, which is driven to the host as an active-high request line. A second control field holds an 8-bit acknowledge time limit.

After the host asserts its DMA acknowledge, a timer counts prescaled ticks until the host issues an I/O read or write strobe. During a write-verify pass the host may never issue a strobe. If the limit is exceeded, the block runs one dummy transfer on the card side. This transfer is a read strobe whose data is thrown away, and it delivers the acknowledge and terminal-count status to the card. A host strobe that arrives during the dummy transfer is held off with a wait signal until the dummy transfer completes.

Top module: `dma_ack_watchdog`

## Requirements
- R1: After reset the mode field is 00 and the limit is 0. No request reaches the host and no dummy transfer occurs.
- R2: With mode 00, `host_drq` stays low whatever the card pins do. No dummy transfer starts even when the acknowledge is held for a long time.
- R3: A configuration write with `cfg_addr`=0 loads the mode from `cfg_wdata[7:6]`, and one with `cfg_addr`=1 loads the limit from `cfg_wdata[7:0]`. `host_drq` is high when the pin picked by the mode is low. Mode 01 picks `card_inpack_n`, 10 picks `card_wpio_n` and 11 picks `card_bvd_n`.
- R4: With limit D>0 the timer counts one step per clock edge at which the acknowledge is sampled low and no strobe has yet been seen. The dummy transfer starts at the edge that makes this count (D+1)·PRESCALE.
- R5: A host read or write strobe sampled during the acknowledge stops the timer for the rest of that acknowledge.
- R6: A limit of 0 disables the watchdog.
- R7: A dummy transfer holds `card_rd_n` low for exactly DUMMY_CLKS cycles and holds `card_dack` high. During it `card_tc` equals the host terminal count captured at the start. `dummy_done` pulses for one cycle right after it ends.
- R8: Only one dummy transfer happens per acknowledge assertion. The timer rearms after the acknowledge is released and asserted again.
- R9: While a dummy transfer runs, a host strobe raises `host_wait` and the host write strobe is kept off the card. Once the dummy transfer ends, host strobes pass to the card.
- R10: In DMA mode `card_dack` follows the host acknowledge, and `card_tc` equals `host_tc` while the acknowledge is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 1 | 0 = mode field, 1 = time limit |
| cfg_wdata | input | 8 | Configuration write data |
| card_inpack_n | input | 1 | Card pin, request source for mode 01 |
| card_wpio_n | input | 1 | Card pin, request source for mode 10 |
| card_bvd_n | input | 1 | Card pin, request source for mode 11 |
| host_dack_n | input | 1 | Host DMA acknowledge, active low |
| host_ior_n | input | 1 | Host I/O read strobe, active low |
| host_iow_n | input | 1 | Host I/O write strobe, active low |
| host_tc | input | 1 | Host terminal count |
| host_drq | output | 1 | DMA request to host, active high |
| host_wait | output | 1 | Holds off a host strobe during a dummy transfer |
| card_dack | output | 1 | Acknowledge to card |
| card_tc | output | 1 | Terminal count to card |
| card_rd_n | output | 1 | Card read strobe, active low |
| card_wr_n | output | 1 | Card write strobe, active low |
| dummy_done | output | 1 | One-cycle pulse at the end of a dummy transfer |

## Verification
The bench checks the exact edge at which a dummy transfer starts. A timer that is off by one tick or one prescale step moves `card_rd_n` one or more cycles early or late, and the per-clock model comparison catches the change. Other tests hold the acknowledge long after a timeout, and cut the acknowledge short with a single-cycle strobe. A design that retriggers or that ignores the strobe would then produce extra `dummy_done` pulses. A host read issued during a dummy transfer checks that `host_wait` rises and that `card_tc` stays latched. A final scenario releases and reasserts the acknowledge and checks that a second dummy transfer follows.

// File: rtl/dma_ack_watchdog.sv
module dma_ack_watchdog #(
  parameter int PRESCALE   = 4,
  parameter int DUMMY_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       card_inpack_n,
  input  logic       card_wpio_n,
  input  logic       card_bvd_n,
  input  logic       host_dack_n,
  input  logic       host_ior_n,
  input  logic       host_iow_n,
  input  logic       host_tc,
  output logic       host_drq,
  output logic       host_wait,
  output logic       card_dack,
  output logic       card_tc,
  output logic       card_rd_n,
  output logic       card_wr_n,
  output logic       dummy_done
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int DW = (DUMMY_CLKS > 1) ? $clog2(DUMMY_CLKS) : 1;

  logic [1:0]    mode;
  logic [7:0]    limit;
  logic [PW-1:0] pre;
  logic [7:0]    ticks;
  logic          seen, fired;
  logic          dummy_active;
  logic [DW-1:0] dcnt;
  logic          tc_lat;

  wire dma_on    = mode != 2'b00;
  wire ack_act   = dma_on & ~host_dack_n;
  wire strobe    = ~host_ior_n | ~host_iow_n;
  wire timing    = ack_act & ~strobe & ~seen & ~fired & (limit != 8'd0);
  wire pre_wrap  = pre == PW'(PRESCALE - 1);
  wire start     = timing & pre_wrap & (ticks == limit);

  logic sel_req_n;
  always_comb begin
    case (mode)
      2'b01:   sel_req_n = card_inpack_n;
      2'b10:   sel_req_n = card_wpio_n;
      2'b11:   sel_req_n = card_bvd_n;
      default: sel_req_n = 1'b1;
    endcase
  end

  assign host_drq  = dma_on & ~sel_req_n;
  assign card_dack = dummy_active | ack_act;
  assign card_tc   = dummy_active ? tc_lat : (ack_act & host_tc);
  assign card_rd_n = ~(dummy_active | ~host_ior_n);
  assign card_wr_n = host_iow_n | dummy_active;
  assign host_wait = dummy_active & strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= 2'b00;
      limit <= 8'd0;
    end else if (cfg_we) begin
      if (cfg_addr) limit <= cfg_wdata;
      else          mode  <= cfg_wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      ticks <= '0;
      seen  <= 1'b0;
      fired <= 1'b0;
    end else if (!ack_act) begin
      pre   <= '0;
      ticks <= '0;
      seen  <= 1'b0;
      fired <= 1'b0;
    end else if (strobe) begin
      seen <= 1'b1;
    end else if (timing) begin
      if (pre_wrap) begin
        pre   <= '0;
        ticks <= ticks + 8'd1;
        if (start) fired <= 1'b1;
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dummy_active <= 1'b0;
      dcnt         <= '0;
      tc_lat       <= 1'b0;
      dummy_done   <= 1'b0;
    end else begin
      dummy_done <= 1'b0;
      if (start && !dummy_active) begin
        dummy_active <= 1'b1;
        dcnt         <= '0;
        tc_lat       <= host_tc;
      end else if (dummy_active) begin
        if (dcnt == DW'(DUMMY_CLKS - 1)) begin
          dummy_active <= 1'b0;
          dummy_done   <= 1'b1;
        end else begin
          dcnt <= dcnt + DW'(1);
        end
      end
    end
  end
endmodule

module dma_ack_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [7:0] limit,
  input logic       fired,
  input logic       dummy_active,
  input logic       dummy_done,
  input logic       host_drq,
  input logic       host_wait,
  input logic       card_dack,
  input logic       card_tc,
  input logic       card_rd_n,
  input logic       card_wr_n
);
  assert_drq_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !host_drq);
  assert_done_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dummy_active) |-> dummy_done);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_done |=> !dummy_done);
  assert_dummy_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_active |-> (!card_rd_n && card_dack));
  assert_tc_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_active && $past(dummy_active)) |-> $stable(card_tc));
  assert_zero_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dummy_active) |-> ($past(limit) != 8'd0));
  assert_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dummy_active) |-> !$past(fired));
  assert_wait_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wait |-> card_wr_n);
endmodule

bind dma_ack_watchdog dma_ack_watchdog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .limit(limit), .fired(fired),
  .dummy_active(dummy_active), .dummy_done(dummy_done), .host_drq(host_drq),
  .host_wait(host_wait), .card_dack(card_dack), .card_tc(card_tc),
  .card_rd_n(card_rd_n), .card_wr_n(card_wr_n)
);

// File: tb/dma_ack_watchdog_tb_top.sv
module dma_ack_watchdog_tb_top;
  localparam int PRE = 4;
  localparam int DUM = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic inpack_n = 1, wpio_n = 1, bvd_n = 1;
  logic dack_n = 1, ior_n = 1, iow_n = 1, tc = 0;
  logic drq, hwait, cdack, ctc, crd_n, cwr_n, done;

  int checks = 0, failures = 0, done_seen = 0;

  always #5 clk = ~clk;

  dma_ack_watchdog #(.PRESCALE(PRE), .DUMMY_CLKS(DUM)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .card_inpack_n(inpack_n), .card_wpio_n(wpio_n),
    .card_bvd_n(bvd_n), .host_dack_n(dack_n), .host_ior_n(ior_n),
    .host_iow_n(iow_n), .host_tc(tc), .host_drq(drq), .host_wait(hwait),
    .card_dack(cdack), .card_tc(ctc), .card_rd_n(crd_n), .card_wr_n(cwr_n),
    .dummy_done(done));

  // behavioural reference model
  int m_mode = 0, m_limit = 0, m_cnt = 0, m_left = 0;
  bit m_seen = 0, m_fired = 0, m_done = 0, m_tcl = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_limit = 0; m_cnt = 0; m_left = 0;
      m_seen = 0; m_fired = 0; m_done = 0; m_tcl = 0;
    end else begin
      bit act, strb, go;
      act  = (m_mode != 0) && !dack_n;
      strb = !ior_n || !iow_n;
      go   = 0;
      if (!act) begin m_cnt = 0; m_seen = 0; m_fired = 0; end
      else if (strb) m_seen = 1;
      else if (!m_seen && !m_fired && m_limit != 0) begin
        m_cnt++;
        if (m_cnt == (m_limit + 1) * PRE) begin m_fired = 1; go = 1; end
      end
      m_done = 0;
      if (m_left > 0) begin m_left--; if (m_left == 0) m_done = 1; end
      else if (go) begin m_left = DUM; m_tcl = tc; end
      if (cfg_we) begin
        if (cfg_addr) m_limit = cfg_wdata;
        else m_mode = cfg_wdata[7:6];
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit ma, e_drq, e_dack, e_tc;
    bit sel;
    ma  = m_left > 0;
    sel = (m_mode == 1) ? !inpack_n : (m_mode == 2) ? !wpio_n : (m_mode == 3) ? !bvd_n : 0;
    e_drq  = sel;
    e_dack = ma || ((m_mode != 0) && !dack_n);
    e_tc   = ma ? m_tcl : ((m_mode != 0) && !dack_n && tc);
    chk("R3", "host_drq", drq, e_drq);
    chk("R10", "card_dack", cdack, e_dack);
    chk("R7", "card_tc", ctc, e_tc);
    chk("R7", "card_rd_n", crd_n, !(ma || !ior_n));
    chk("R9", "card_wr_n", cwr_n, iow_n || ma);
    chk("R9", "host_wait", hwait, ma && (!ior_n || !iow_n));
    chk("R7", "dummy_done", done, m_done);
    if (done) done_seen++;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; compare();
    end
  endtask

  task automatic cfg(input bit a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    cyc(1);
    cfg_we = 0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, ack held, pins low
    inpack_n = 0; wpio_n = 0; bvd_n = 0; dack_n = 0;
    done_seen = 0;
    cyc(30);
    chk("R1", "dummies after reset", done_seen, 0);
    dack_n = 1; cyc(2);

    // R2: mode 00, nonzero limit, long ack
    cfg(1, 8'd2);
    dack_n = 0; done_seen = 0;
    cyc(50);
    chk("R2", "dummies in mode 00", done_seen, 0);
    chk("R2", "drq in mode 00", drq, 0);
    dack_n = 1; cyc(2);

    // R3: routing per mode
    inpack_n = 1; wpio_n = 1; bvd_n = 1;
    for (int m = 1; m < 4; m++) begin
      cfg(0, 8'(m << 6));
      inpack_n = 0; cyc(2); chk("R3", "inpack route", drq, m == 1);
      inpack_n = 1; wpio_n = 0; cyc(2); chk("R3", "wpio route", drq, m == 2);
      wpio_n = 1; bvd_n = 0; cyc(2); chk("R3", "bvd route", drq, m == 3);
      bvd_n = 1; cyc(1);
    end

    // R4 R7 R8: timeout with limit 2, ack held well beyond
    cfg(0, 8'h40);
    tc = 1; dack_n = 0; done_seen = 0;
    cyc(11);
    chk("R4", "rd_n before timeout", crd_n, 1);
    cyc(1);
    chk("R4", "rd_n at timeout", crd_n, 0);
    cyc(30);
    chk("R8", "single dummy per ack", done_seen, 1);
    dack_n = 1; tc = 0; cyc(2);

    // R5: strobe cancels the timer
    dack_n = 0; done_seen = 0;
    cyc(4); ior_n = 0; cyc(1); ior_n = 1;
    cyc(30);
    chk("R5", "dummies after strobe", done_seen, 0);
    dack_n = 1; cyc(2);

    // R6: limit zero
    cfg(1, 8'd0);
    dack_n = 0; done_seen = 0;
    cyc(40);
    chk("R6", "dummies with limit 0", done_seen, 0);
    dack_n = 1; cyc(2);

    // R9: host read during dummy
    cfg(1, 8'd1);
    tc = 1; dack_n = 0; done_seen = 0;
    cyc(8);
    tc = 0; ior_n = 0;
    cyc(1);
    chk("R9", "wait during dummy", hwait, 1);
    cyc(3);
    chk("R9", "read passes after dummy", crd_n, 0);
    chk("R9", "wait released", hwait, 0);
    ior_n = 1; cyc(3);
    chk("R7", "one done pulse", done_seen, 1);

    // R8: rearm after release
    dack_n = 1; cyc(2);
    dack_n = 0; done_seen = 0;
    cyc(20);
    chk("R8", "rearmed dummy", done_seen, 1);
    dack_n = 1; cyc(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule